// File: doc/BRIEF.md
# Time-to-digital converter chip bus bridge

This block is a Wishbone classic slave that turns each single read or write cycle into a fixed-timing strobe sequence on the parallel bus of an external time-to-digital converter. The converter's bus has active-low chip-select, write, read and output-enable strobes, a 4-bit address and a 28-bit data bus that both sides share. An acquisition engine elsewhere in the fabric is the bus master. It uses the bridge to write the converter's configuration and to pull timestamps out of the converter's two FIFOs.

A read is sized so that one timestamp can be taken every four system clocks. The converter's two FIFO empty flags cross into the system clock domain through a synchronizer. They are then available both as plain outputs and in the top bits of every read word. The acquisition engine can therefore pace its reads from the same word that carries the timestamp.

Top module: `tdc_bus_bridge`

## Requirements
- R1: While rst_ni is low, chip_cs_no, chip_wr_no, chip_rd_no and chip_oe_no are high, chip_data_io is released (high impedance), wb_ack_o is low and ef_o is 2'b11 (both FIFOs treated as empty).
- R2: A read is accepted at a clock edge where wb_cyc_i and wb_stb_i are high, wb_we_i is low and the bridge is idle. From that edge, chip_cs_no, chip_rd_no and chip_oe_no are low for RD_CYCLES (default 2) cycles, and chip_addr_o carries wb_adr_i.
- R3: The read word is sampled at the edge that ends the read strobes. Bit 31 holds synchronized FIFO-1 empty (ef bit 0), bit 30 holds synchronized FIFO-2 empty (ef bit 1), bits 29:28 are zero and bits 27:0 hold chip_data_io. Of bits 27:0, bits 16:0 are the stop-minus-start value.
- R4: wb_ack_o is high for exactly one cycle per access. For a read it rises with the release of the strobes. For a write it rises with the release of chip-select and data. The cycle after the acknowledge never starts an access, so back-to-back reads complete once every 4 cycles.
- R5: A write drives chip_addr_o and chip_data_io (wb_dat_i) with chip_cs_no low for one cycle before chip_wr_no falls. chip_wr_no stays low for WR_CYCLES (default 2) cycles. Address and data stay driven, with chip_cs_no low, for one cycle after chip_wr_no rises.
- R6: The bridge drives chip_data_io only during the setup, strobe and hold cycles of a write. At all other times it leaves the bus in high impedance.
- R7: wb_cyc_i, wb_stb_i, wb_we_i, wb_adr_i and wb_dat_i are ignored from the accepting edge until the cycle after the acknowledge. The address and data of an access in progress do not change.
- R8: ef_o follows chip_ef_i through a two-stage synchronizer: a change at the input shows at ef_o after the second clock edge.
- R9: chip_rd_no and chip_wr_no are never low together. chip_oe_no is low only during read strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Strobe |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | 4 | Converter register address |
| wb_dat_i | input | 28 | Write data |
| wb_dat_o | output | 32 | Read word: flags in 31:30, chip data in 27:0 |
| wb_ack_o | output | 1 | One-cycle acknowledge |
| chip_cs_no | output | 1 | Chip select, active low |
| chip_wr_no | output | 1 | Write strobe, active low |
| chip_rd_no | output | 1 | Read strobe, active low |
| chip_oe_no | output | 1 | Output enable, active low |
| chip_addr_o | output | 4 | Chip address bus |
| chip_data_io | inout | 28 | Shared chip data bus |
| chip_ef_i | input | 2 | FIFO empty flags from chip, bit 0 = FIFO 1 |
| ef_o | output | 2 | Synchronized empty flags |

## Verification
The sampling of a read word and a change of the FIFO empty flags can fall in the same cycle. The flag bits in the word must then come from the synchronizer output as it stood just before the sampling edge, not from the value it takes after that edge. The bench provokes this by toggling chip_ef_i on every cycle while back-to-back reads keep wb_stb_i high. A bus model then compares each acknowledged word against a flag pipeline that the bench keeps on its own. The same random phase also lands new requests on the acknowledge and the following cycle, which checks that they are ignored there and accepted exactly one cycle later.

// File: rtl/tdc_bus_bridge_pkg.sv
package tdc_bus_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WSTROBE,
    ST_WHOLD,
    ST_ACK
  } bridge_state_e;

  typedef struct packed {
    logic cs_n;
    logic wr_n;
    logic rd_n;
    logic oe_n;
  } strobe_t;

  localparam strobe_t STROBE_OFF = '{cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1, oe_n: 1'b1};

endpackage

// File: rtl/tdc_flag_sync.sv
module tdc_flag_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RESET_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/tdc_bus_seq.sv
module tdc_bus_seq
  import tdc_bus_bridge_pkg::*;
#(
  parameter int unsigned RD_CYCLES = 2,
  parameter int unsigned WR_CYCLES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    we_i,
  output logic    load_o,
  output logic    capture_o,
  output logic    drive_o,
  output logic    ack_o,
  output strobe_t strobe_o
);
  localparam int unsigned MAX_CYC = (RD_CYCLES > WR_CYCLES) ? RD_CYCLES : WR_CYCLES;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYCLES - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_CYCLES - 1);

  bridge_state_e    state_q;
  logic [CNT_W-1:0] cnt_q;

  assign load_o    = (state_q == ST_IDLE) && req_i;
  assign capture_o = (state_q == ST_READ) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      drive_o  <= 1'b0;
      ack_o    <= 1'b0;
      strobe_o <= STROBE_OFF;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            strobe_o.cs_n <= 1'b0;
            if (we_i) begin
              drive_o <= 1'b1;
              state_q <= ST_WSETUP;
            end else begin
              strobe_o.rd_n <= 1'b0;
              strobe_o.oe_n <= 1'b0;
              cnt_q         <= RD_LAST;
              state_q       <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (cnt_q == '0) begin
            strobe_o <= STROBE_OFF;
            ack_o    <= 1'b1;
            state_q  <= ST_ACK;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WSETUP: begin
          strobe_o.wr_n <= 1'b0;
          cnt_q         <= WR_LAST;
          state_q       <= ST_WSTROBE;
        end
        ST_WSTROBE: begin
          if (cnt_q == '0) begin
            strobe_o.wr_n <= 1'b1;
            state_q       <= ST_WHOLD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WHOLD: begin
          strobe_o <= STROBE_OFF;
          drive_o  <= 1'b0;
          ack_o    <= 1'b1;
          state_q  <= ST_ACK;
        end
        ST_ACK: begin
          // turnaround cycle: requests still ignored here
          ack_o   <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tdc_bus_datapath.sv
module tdc_bus_datapath #(
  parameter int unsigned DATA_W = 28,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              capture_i,
  input  logic              drive_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [DATA_W-1:0] dat_i,
  input  logic [1:0]        ef_i,
  output logic [ADDR_W-1:0] chip_addr_o,
  inout  wire  [DATA_W-1:0] chip_data_io,
  output logic [WORD_W-1:0] dat_o,
  output logic [1:0]        ef_o
);
  logic [DATA_W-1:0] wdata_q;
  logic [WORD_W-1:0] rword_d;

  for (genvar g = 0; g < 2; g++) begin : g_sync
    tdc_flag_sync #(.STAGES(SYNC_N), .RESET_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (ef_i[g]),
      .q_o   (ef_o[g])
    );
  end

  assign chip_data_io = drive_i ? wdata_q : {DATA_W{1'bz}};

  always_comb begin
    rword_d                = '0;
    rword_d[WORD_W-1]      = ef_o[0];
    rword_d[WORD_W-2]      = ef_o[1];
    rword_d[DATA_W-1:0]    = chip_data_io;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chip_addr_o <= '0;
      wdata_q     <= '0;
      dat_o       <= '0;
    end else begin
      if (load_i) begin
        chip_addr_o <= adr_i;
        wdata_q     <= dat_i;
      end
      if (capture_i) dat_o <= rword_d;
    end
  end
endmodule

// File: rtl/tdc_bus_bridge.sv
module tdc_bus_bridge
  import tdc_bus_bridge_pkg::*;
#(
  parameter int unsigned DATA_W    = 28,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned RD_CYCLES = 2,
  parameter int unsigned WR_CYCLES = 2,
  parameter int unsigned SYNC_N    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic [WORD_W-1:0] wb_dat_o,
  output logic              wb_ack_o,
  output logic              chip_cs_no,
  output logic              chip_wr_no,
  output logic              chip_rd_no,
  output logic              chip_oe_no,
  output logic [ADDR_W-1:0] chip_addr_o,
  inout  wire  [DATA_W-1:0] chip_data_io,
  input  logic [1:0]        chip_ef_i,
  output logic [1:0]        ef_o
);
  logic    load, capture, drive_en;
  strobe_t strobe;

  tdc_bus_seq #(.RD_CYCLES(RD_CYCLES), .WR_CYCLES(WR_CYCLES)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (wb_cyc_i & wb_stb_i),
    .we_i     (wb_we_i),
    .load_o   (load),
    .capture_o(capture),
    .drive_o  (drive_en),
    .ack_o    (wb_ack_o),
    .strobe_o (strobe)
  );

  tdc_bus_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SYNC_N(SYNC_N)
  ) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .capture_i   (capture),
    .drive_i     (drive_en),
    .adr_i       (wb_adr_i),
    .dat_i       (wb_dat_i),
    .ef_i        (chip_ef_i),
    .chip_addr_o (chip_addr_o),
    .chip_data_io(chip_data_io),
    .dat_o       (wb_dat_o),
    .ef_o        (ef_o)
  );

  assign chip_cs_no = strobe.cs_n;
  assign chip_wr_no = strobe.wr_n;
  assign chip_rd_no = strobe.rd_n;
  assign chip_oe_no = strobe.oe_n;
endmodule

// File: rtl/tdc_bus_bridge_chk.sv
module tdc_bus_bridge_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n,
  input logic              wr_n,
  input logic              rd_n,
  input logic              oe_n,
  input logic              ack,
  input logic              drive,
  input logic [ADDR_W-1:0] addr
);
  assert_ack_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |=> !ack);

  assert_ack_after_select_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack) |-> $past(!cs_n));

  assert_read_ends_with_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_n) |-> ack);

  assert_read_strobes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n |-> (!cs_n && !oe_n));

  assert_write_setup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_n) |-> (drive && $past(drive) && $stable(addr)));

  assert_write_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_n) |-> (drive && !cs_n && $stable(addr)));

  assert_drive_in_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive |-> (!cs_n && oe_n && rd_n));

  assert_no_double_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n && !wr_n));

  assert_oe_only_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n |-> !rd_n);
endmodule

bind tdc_bus_bridge tdc_bus_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cs_n  (chip_cs_no),
  .wr_n  (chip_wr_no),
  .rd_n  (chip_rd_no),
  .oe_n  (chip_oe_no),
  .ack   (wb_ack_o),
  .drive (drive_en),
  .addr  (chip_addr_o)
);

// File: tb/tdc_bus_bridge_test.sv
`timescale 1ns/1ps
module tdc_bus_bridge_test;
  localparam int DW = 28;
  localparam int AW = 4;
  localparam int RD_N = 2;
  localparam int WR_N = 2;

  typedef struct packed {
    logic cs_n, wr_n, rd_n, oe_n, drv, ack, is_rd;
  } exp_t;

  localparam exp_t E_IDLE = 7'b1111000;
  localparam exp_t E_RSTB = 7'b0100000;
  localparam exp_t E_RACK = 7'b1111011;
  localparam exp_t E_WSET = 7'b0111100;
  localparam exp_t E_WSTB = 7'b0011100;
  localparam exp_t E_WACK = 7'b1111010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [AW-1:0] adr = '0;
  logic [DW-1:0] dat = '0;
  logic [1:0] ef_in = 2'b11;
  logic [31:0] dat_o;
  logic ack, cs_n, wr_n, rd_n, oe_n;
  logic [AW-1:0] caddr;
  wire  [DW-1:0] cdata;
  logic [1:0] ef_o;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tdc_bus_bridge uut (
    .clk_i(clk), .rst_ni(rst_n),
    .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr), .wb_dat_i(dat),
    .wb_dat_o(dat_o), .wb_ack_o(ack),
    .chip_cs_no(cs_n), .chip_wr_no(wr_n), .chip_rd_no(rd_n), .chip_oe_no(oe_n),
    .chip_addr_o(caddr), .chip_data_io(cdata),
    .chip_ef_i(ef_in), .ef_o(ef_o)
  );

  // chip bus model
  logic [DW-1:0] cmem [16];
  assign cdata = (!cs_n && !oe_n) ? cmem[caddr] : {DW{1'bz}};
  always @(posedge wr_n) if (cs_n === 1'b0) cmem[caddr] <= cdata;

  // reference model
  logic [DW-1:0] smem [16];
  exp_t q[$];
  exp_t cur;
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_wdata;
  logic [31:0] e_word;
  logic [1:0] s1, s2;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, expv);
    end
  endtask

  always @(posedge clk) begin
    logic [1:0] s2_old;
    if (!rst_n) begin
      q.delete();
      cur = E_IDLE;
      s1 = 2'b11; s2 = 2'b11;
      #1;
      // R1 reset state
      chk({cs_n, wr_n, rd_n, oe_n} === 4'hF, "R1 strobes", {28'd0, cs_n, wr_n, rd_n, oe_n}, 32'hF);
      chk(ack === 1'b0, "R1 ack", {31'd0, ack}, 32'd0);
      chk(cdata === {DW{1'bz}}, "R1 bus", {4'd0, cdata}, 32'd0);
      chk(ef_o === 2'b11, "R1 ef_o", {30'd0, ef_o}, 32'd3);
    end else begin
      s2_old = s2;
      if (q.size() == 0 && cyc && stb) begin
        e_addr = adr;
        if (we) begin
          e_wdata = dat;
          smem[adr] = dat;
          q.push_back(E_WSET);
          for (int i = 0; i < WR_N; i++) q.push_back(E_WSTB);
          q.push_back(E_WSET);
          q.push_back(E_WACK);
        end else begin
          for (int i = 0; i < RD_N; i++) q.push_back(E_RSTB);
          q.push_back(E_RACK);
        end
        q.push_back(E_IDLE);
      end
      cur = (q.size() != 0) ? q.pop_front() : E_IDLE;
      if (cur.ack && cur.is_rd) e_word = {s2_old[0], s2_old[1], 2'b00, smem[e_addr]};
      s2 = s1;
      s1 = ef_in;
      #1;
      chk(cs_n === cur.cs_n, "R2/cs", {31'd0, cs_n}, {31'd0, cur.cs_n});
      chk(rd_n === cur.rd_n, "R2 rd_n", {31'd0, rd_n}, {31'd0, cur.rd_n});
      chk(wr_n === cur.wr_n, "R5 wr_n", {31'd0, wr_n}, {31'd0, cur.wr_n});
      chk(oe_n === cur.oe_n, "R9 oe_n", {31'd0, oe_n}, {31'd0, cur.oe_n});
      chk(ack === cur.ack, "R4 ack", {31'd0, ack}, {31'd0, cur.ack});
      if (cur.ack && cur.is_rd)
        chk(dat_o === e_word, "R3 read word", dat_o, e_word);
      if (!cur.cs_n)
        chk(caddr === e_addr, "R7 held address", {28'd0, caddr}, {28'd0, e_addr});
      if (cur.drv)
        chk(cdata === e_wdata, "R5 write data", {4'd0, cdata}, {4'd0, e_wdata});
      else if (cur.oe_n)
        chk(cdata === {DW{1'bz}}, "R6 bus released", {4'd0, cdata}, 32'd0);
      chk(ef_o === s2, "R8 ef_o", {30'd0, ef_o}, {30'd0, s2});
    end
  end

  task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; dat = d;
    do @(negedge clk); while (ack !== 1'b1);
    cyc = 1'b0; stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      cmem[i] = DW'(i * 32'h0123457 + 32'h5a5);
      smem[i] = cmem[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R5 writes with edge patterns
    access(1'b1, 4'd0, '0);
    access(1'b1, 4'd15, {DW{1'b1}});
    access(1'b1, 4'd5, 28'h0A5F00D);
    // R2 R3 reads, flags changed between
    access(1'b0, 4'd15, '0);
    ef_in = 2'b01;
    repeat (4) @(negedge clk);
    access(1'b0, 4'd0, '0);
    ef_in = 2'b10;
    repeat (4) @(negedge clk);
    access(1'b0, 4'd5, '0);
    // R4 back-to-back reads, flags toggling every cycle (R3/R8 collision)
    cyc = 1'b1; stb = 1'b1; we = 1'b0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      adr = AW'(i);
      ef_in = ef_in ^ 2'(i + 1);
    end
    cyc = 1'b0; stb = 1'b0;
    repeat (4) @(negedge clk);
    // R7 R9 random storm: requests land during accesses
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      cyc = 1'($urandom());
      stb = 1'($urandom_range(0, 3) != 0);
      we  = 1'($urandom());
      adr = AW'($urandom());
      dat = DW'($urandom());
      ef_in = 2'($urandom());
    end
    cyc = 1'b0; stb = 1'b0;
    repeat (8) @(negedge clk);
    // read back every location after the storm
    for (int i = 0; i < 16; i++) access(1'b0, AW'(i), '0);
    finished = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end
endmodule